// File: doc/BRIEF.md
# PFC Protection Supervisor

This block watches a transition-mode power-factor-correction stage and decides, on every clock, whether the PFC gate may be driven. It receives the gate request from the PFC control loop and three sampled millivolt codes. One code is the inductor current-sense level. One is a divided copy of the output bus. The third is the error-amplifier feedback input. From these it produces a gated gate-enable and a latched global fault request.

Two bus conditions suspend switching without latching, each with its own hysteresis:

- an over-voltage band near the top of the monitor range;
- a shutdown band near the bottom of the monitor range.

Two conditions set the fault latch:

- The feedback voltage collapses while the over-voltage state is active. This is the signature of an open feedback divider.
- The current-sense level exceeds the saturation level while the gate is on and leading-edge blanking has expired.

Blanking is a cycle counter that restarts on every rising edge of the gate-enable. The fault latch clears only through the synchronous supply-fail reset.

Top module: `pfc_guard`

## Requirements
- R1: While `rst` is high at a clock edge, every internal state is cleared. After that edge `fault_latched` is 0, and with nominal codes `gate_en` equals `gate_req`.
- R2: `gate_en` is combinational. It is 1 in the same cycle as `gate_req` is 1, provided that none of these is active: the over-voltage state, the shutdown state, the fault latch.
- R3: A `bus_code` strictly above `OVP_SET_MV` at a clock edge sets the over-voltage state. `gate_en` is 0 from the next cycle.
- R4: The over-voltage state clears only at an edge where `bus_code` is strictly below `OVP_CLR_MV`. Between the two levels it holds. It never sets the fault latch.
- R5: A `bus_code` strictly below `DIS_SET_MV` sets an unlatched shutdown state, which holds `gate_en` at 0. The state clears only when `bus_code` is strictly above `DIS_CLR_MV`.
- R6: The fault latch sets at an edge where two things are true together: the over-voltage state is active and `fb_code` is strictly below `OPEN_FB_MV`.
- R7: The fault latch sets at an edge where `gate_en` is 1, blanking has expired and `cs_code` is strictly above `SAT_MV`. Current-sense levels while `gate_en` is 0 are ignored.
- R8: Call the first cycle of a new `gate_en` high period cycle 0. Blanking ignores `cs_code` in cycles 0 through `BLANK_CYC-1` of that period. Every new rising edge of `gate_en` restarts the count from cycle 0.
- R9: Once set, `fault_latched` stays 1 and `gate_en` stays 0 until `rst`. This holds even after the over-voltage or shutdown condition goes away.
- R10: Each threshold compare is strict. A code exactly equal to `OVP_SET_MV`, `SAT_MV` or `OPEN_FB_MV` does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous supply-fail reset, active high |
| gate_req | input | 1 | Gate request from the PFC control loop |
| cs_code | input | CODE_W | Current-sense sample, mV |
| bus_code | input | CODE_W | Divided output-bus monitor, mV |
| fb_code | input | CODE_W | Feedback input sample, mV |
| gate_en | output | 1 | Qualified PFC gate enable |
| fault_latched | output | 1 | Latched global stop request |

## Verification
The assertions check on every cycle the rules that apply in each state of the block:

- set, clear and hold for both hysteresis comparators;
- persistence of the fault latch, and that the latch does not set without a cause;
- that a saturation hit or an open-loop hit is followed by the latch;
- that blanking is active in the cycle after a gate rise.

Only the bench scenarios can show the behaviour across a sequence of cycles. The bench sweeps the exact blanking window edge, including a restart after a short gate-low gap. It walks the bus code through full up-and-down ramps across both hysteresis bands. It also shows that an over-voltage that is released leaves no latched trace, and that the latch survives until reset.

// File: rtl/pfc_guard_pkg.sv
package pfc_guard_pkg;
   // Which side of the set level trips a hysteresis comparator
   typedef enum logic {
      HYST_RISE = 1'b0,  // trips above SET, releases below CLR (CLR < SET)
      HYST_FALL = 1'b1   // trips below SET, releases above CLR (CLR > SET)
   } hyst_dir_e;
endpackage

// File: rtl/pfc_hyst_cmp.sv
module pfc_hyst_cmp
   import pfc_guard_pkg::*;
#(
   parameter int        CODE_W = 12,
   parameter int        SET_MV = 3400,
   parameter int        CLR_MV = 3260,
   parameter hyst_dir_e DIR    = HYST_RISE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] in_code,
   output logic              active
);
   localparam logic [CODE_W-1:0] SET_C = CODE_W'(SET_MV);
   localparam logic [CODE_W-1:0] CLR_C = CODE_W'(CLR_MV);

   if (SET_MV >= (1 << CODE_W) || CLR_MV >= (1 << CODE_W)) begin : g_bad_range
      $error("pfc_hyst_cmp: level does not fit CODE_W");
   end

   logic trip, release_c, state_q;

   if (DIR == HYST_RISE) begin : g_rise
      if (CLR_MV >= SET_MV) begin : g_bad_order
         $error("pfc_hyst_cmp: rising comparator needs CLR_MV < SET_MV");
      end
      assign trip      = in_code > SET_C;
      assign release_c = in_code < CLR_C;
   end else begin : g_fall
      if (CLR_MV <= SET_MV) begin : g_bad_order
         $error("pfc_hyst_cmp: falling comparator needs CLR_MV > SET_MV");
      end
      assign trip      = in_code < SET_C;
      assign release_c = in_code > CLR_C;
   end

   always_ff @(posedge clk) begin
      if (rst)            state_q <= 1'b0;
      else if (trip)      state_q <= 1'b1;
      else if (release_c) state_q <= 1'b0;
   end

   assign active = state_q;

   AST_HYST_SET: assert property (@(posedge clk) disable iff (rst)
      trip |=> active);                                        // R3
   AST_HYST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (release_c && !trip) |=> !active);                       // R4
   AST_HYST_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!trip && !release_c) |=> $stable(active));              // R5
endmodule

// File: rtl/pfc_blank_timer.sv
module pfc_blank_timer #(
   parameter int BLANK_CYC = 40
) (
   input  logic clk,
   input  logic rst,
   input  logic gate_on,
   output logic blank
);
   if (BLANK_CYC < 0) begin : g_bad_blank
      $error("pfc_blank_timer: BLANK_CYC must not be negative");
   end

   if (BLANK_CYC == 0) begin : g_none
      assign blank = 1'b0;
   end else begin : g_count
      localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
      localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

      logic          gate_d;
      logic [CW-1:0] cnt_q;
      logic          rise;

      assign rise = gate_on & ~gate_d;

      always_ff @(posedge clk) begin
         if (rst) begin
            gate_d <= 1'b0;
            cnt_q  <= '0;
         end else begin
            gate_d <= gate_on;
            if (rise)             cnt_q <= LOAD;
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
      end

      assign blank = rise | (cnt_q != '0);

      if (BLANK_CYC > 1) begin : g_chk
         AST_BLANK_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
            rise |=> (!gate_on || blank));                     // R8
      end
   end
endmodule

// File: rtl/pfc_fault_latch.sv
module pfc_fault_latch #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src,
   output logic            fault
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("pfc_fault_latch: NSRC must be at least 1");
   end

   logic fault_q;

   always_ff @(posedge clk) begin
      if (rst)       fault_q <= 1'b0;
      else if (|src) fault_q <= 1'b1;
   end

   assign fault = fault_q;

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      fault_q |=> fault_q);                                    // R9
   AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!fault_q && src == '0) |=> !fault_q);                   // R9
endmodule

// File: rtl/pfc_guard.sv
module pfc_guard
   import pfc_guard_pkg::*;
#(
   parameter int CODE_W     = 12,
   parameter int OVP_SET_MV = 3400,
   parameter int OVP_CLR_MV = 3260,
   parameter int DIS_SET_MV = 750,
   parameter int DIS_CLR_MV = 870,
   parameter int OPEN_FB_MV = 1200,
   parameter int SAT_MV     = 1700,
   parameter int BLANK_CYC  = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              gate_req,
   input  logic [CODE_W-1:0] cs_code,
   input  logic [CODE_W-1:0] bus_code,
   input  logic [CODE_W-1:0] fb_code,
   output logic              gate_en,
   output logic              fault_latched
);
   localparam logic [CODE_W-1:0] SAT_C  = CODE_W'(SAT_MV);
   localparam logic [CODE_W-1:0] OPEN_C = CODE_W'(OPEN_FB_MV);
   localparam int                NSRC   = 2;

   if (DIS_CLR_MV >= OVP_CLR_MV) begin : g_bad_bands
      $error("pfc_guard: shutdown band must lie below over-voltage band");
   end
   if (SAT_MV >= (1 << CODE_W) || OPEN_FB_MV >= (1 << CODE_W)) begin : g_bad_lvl
      $error("pfc_guard: level does not fit CODE_W");
   end

   logic            ovp_on, dis_on, blank, fault_q;
   logic            sat_hit, open_hit;
   logic [NSRC-1:0] fault_src;

   pfc_hyst_cmp #(
      .CODE_W(CODE_W), .SET_MV(OVP_SET_MV), .CLR_MV(OVP_CLR_MV), .DIR(HYST_RISE)
   ) u_ovp (
      .clk(clk), .rst(rst), .in_code(bus_code), .active(ovp_on)
   );

   pfc_hyst_cmp #(
      .CODE_W(CODE_W), .SET_MV(DIS_SET_MV), .CLR_MV(DIS_CLR_MV), .DIR(HYST_FALL)
   ) u_dis (
      .clk(clk), .rst(rst), .in_code(bus_code), .active(dis_on)
   );

   assign gate_en = gate_req & ~ovp_on & ~dis_on & ~fault_q;

   pfc_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk(clk), .rst(rst), .gate_on(gate_en), .blank(blank)
   );

   assign sat_hit   = gate_en & ~blank & (cs_code > SAT_C);
   assign open_hit  = ovp_on & (fb_code < OPEN_C);
   assign fault_src = {open_hit, sat_hit};

   pfc_fault_latch #(.NSRC(NSRC)) u_latch (
      .clk(clk), .rst(rst), .src(fault_src), .fault(fault_q)
   );

   assign fault_latched = fault_q;

   AST_SAT_LATCHES: assert property (@(posedge clk) disable iff (rst)
      (gate_en && !blank && cs_code > SAT_C) |=> fault_latched);        // R7
   AST_OPEN_LOOP_LATCHES: assert property (@(posedge clk) disable iff (rst)
      (ovp_on && fb_code < OPEN_C) |=> fault_latched);                  // R6
   AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_latched) |-> !gate_en);                               // R9
endmodule

// File: tb/sim_pfc_guard.sv
`timescale 1ns/1ps
module sim_pfc_guard;
   localparam int W     = 12;
   localparam int OVS   = 3400;
   localparam int OVC   = 3260;
   localparam int DSS   = 750;
   localparam int DSC   = 870;
   localparam int OPN   = 1200;
   localparam int SAT   = 1700;
   localparam int BLANK = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic [W-1:0]  cs = '0, bus = W'(2500), fb = W'(2500);
   logic          gate_en, fault_latched;

   int errors = 0, checks = 0;
   bit done = 0;

   // Reference state kept by the bench
   bit m_ovp, m_dis, m_flt, m_gprev;
   int m_since;

   always #2.5 clk = ~clk;

   pfc_guard #(
      .CODE_W(W), .OVP_SET_MV(OVS), .OVP_CLR_MV(OVC), .DIS_SET_MV(DSS),
      .DIS_CLR_MV(DSC), .OPEN_FB_MV(OPN), .SAT_MV(SAT), .BLANK_CYC(BLANK)
   ) u0 (
      .clk(clk), .rst(rst), .gate_req(req), .cs_code(cs), .bus_code(bus),
      .fb_code(fb), .gate_en(gate_en), .fault_latched(fault_latched)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req = 1'b0; cs = '0; bus = W'(2500); fb = W'(2500);
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      m_ovp = 0; m_dis = 0; m_flt = 0; m_gprev = 0; m_since = 0;
   endtask

   // One cycle: drive at falling edge, check, advance the reference state.
   task automatic cyc(input bit r, input int c, input int b, input int f, input string tag);
      bit exp_gate, sat, opn;
      @(negedge clk);
      req = r; cs = W'(c); bus = W'(b); fb = W'(f);
      #1;
      exp_gate = r && !m_ovp && !m_dis && !m_flt;
      chk(tag, "gate_en", int'(gate_en), int'(exp_gate));
      chk(tag, "fault_latched", int'(fault_latched), int'(m_flt));
      if (exp_gate) m_since = m_gprev ? m_since + 1 : 0;
      sat = exp_gate && (m_since >= BLANK) && (c > SAT);
      opn = m_ovp && (f < OPN);
      if (sat || opn) m_flt = 1;
      if (b > OVS) m_ovp = 1; else if (b < OVC) m_ovp = 0;
      if (b < DSS) m_dis = 1; else if (b > DSC) m_dis = 0;
      m_gprev = exp_gate;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      chk("R1", "fault after reset", int'(fault_latched), 0);
      cyc(1, 0, 2500, 2500, "R1");
      cyc(0, 0, 2500, 2500, "R1");

      // R2: gate transparency under a pattern
      for (int i = 0; i < 16; i++) cyc(((i * 5) % 3) == 1, 0, 2500, 2500, "R2");

      // R3 R4 R10: over-voltage ramp up and down through both levels
      do_reset();
      for (int b = 3200; b <= 3500; b += 10) cyc(1, 0, b, 2500, "R3");
      for (int b = 3500; b >= 3200; b -= 10) cyc(1, 0, b, 2500, "R4");
      cyc(1, 0, OVS, 2500, "R10");
      cyc(1, 0, OVS, 2500, "R10");
      chk("R4", "no latch from over-voltage", int'(fault_latched), 0);

      // R5: shutdown ramp down and up
      do_reset();
      for (int b = 1000; b >= 600; b -= 10) cyc(1, 0, b, 2500, "R5");
      for (int b = 600; b <= 1000; b += 10) cyc(1, 0, b, 2500, "R5");
      chk("R5", "shutdown unlatched", int'(fault_latched), 0);

      // R6: collapsed feedback without over-voltage is harmless
      do_reset();
      for (int f = 1300; f >= 900; f -= 50) cyc(1, 0, 2500, f, "R6");
      // over-voltage with feedback at and above the level, then below
      cyc(1, 0, 3450, 1300, "R6");
      cyc(1, 0, 3450, OPN, "R10");
      cyc(1, 0, 3450, OPN, "R10");
      cyc(1, 0, 3450, 1190, "R6");
      cyc(1, 0, 3450, 1190, "R6");
      // R9: release every condition, latch must persist
      for (int i = 0; i < 6; i++) cyc(1, 0, 2500, 2500, "R9");
      chk("R9", "latched after release", int'(fault_latched), 1);
      do_reset();
      chk("R9", "reset clears latch", int'(fault_latched), 0);
      cyc(1, 0, 2500, 2500, "R9");

      // R8: blanking window edge sweep
      for (int k = 0; k < BLANK + 4; k++) begin
         do_reset();
         cyc(0, 0, 2500, 2500, "R8");
         for (int j = 0; j <= k + 2; j++) cyc(1, (j == k) ? 2000 : 0, 2500, 2500, "R8");
         chk("R8", "fault vs cs offset", int'(fault_latched), (k >= BLANK) ? 1 : 0);
      end
      // R8: restart on a new gate rise
      do_reset();
      cyc(0, 0, 2500, 2500, "R8");
      for (int j = 0; j < BLANK - 1; j++) cyc(1, 0, 2500, 2500, "R8");
      cyc(0, 0, 2500, 2500, "R8");
      for (int j = 0; j < BLANK; j++) cyc(1, (j == BLANK - 2) ? 2000 : 0, 2500, 2500, "R8");
      cyc(1, 0, 2500, 2500, "R8");
      chk("R8", "restarted blanking", int'(fault_latched), 0);

      // R7 R10: saturation level sweep after blanking
      for (int c = SAT - 20; c <= SAT + 20; c += 10) begin
         do_reset();
         cyc(0, 0, 2500, 2500, "R7");
         for (int j = 0; j < BLANK + 3; j++) cyc(1, (j >= BLANK) ? c : 0, 2500, 2500, "R7");
         chk("R10", "sat strict compare", int'(fault_latched), (c > SAT) ? 1 : 0);
      end
      // R7: current sense ignored while gate is off
      do_reset();
      for (int j = 0; j < 10; j++) cyc(0, 3000, 2500, 2500, "R7");
      chk("R7", "sense ignored while gate off", int'(fault_latched), 0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule